// File: doc/BRIEF.md
# Bus Error Capture Register with Lock

This block gathers bus error events into a 32-bit sticky status word. Each implemented bit position has its own single-cycle pulse input. When a pulse arrives, the matching status bit sets and stays set until software clears it by writing a one to it. Software reaches the status word and a small configuration word over a simple register port. The port has an address, a write enable, write data, and a registered read data output.

The block can freeze its contents so that the first failure is kept for diagnosis. It locks in two cases. The first is when an error is captured while the lock-on-first-error enable is set. The second is when any non-syndrome error is captured, whatever that enable says. The four data-syndrome positions never cause a lock on their own.

While the block is locked, new pulses are dropped. Pulses that arrive in the same cycle as the lock event are still recorded. The lock releases in two cases: when the status word becomes all zero, or when software clears the enable bit. An error-present output tells the rest of the system that some status bit is set.

Top module: `bus_err_latch`

## Requirements
- R1: After a synchronous reset the status word, the configuration word, `err_present_o`, `locked_o` and `rd_data_o` are all zero.
- R2: A pulse on an implemented position sets that status bit at the next clock edge, and the bit stays set. The implemented positions are 0-4, 8, 16-18, 20-23, 29 and 31 (mask 0xA0F7011F). Pulses on other positions are ignored, and those positions read as zero.
- R3: Writing to address 0 clears each status bit whose write-data bit is one. Zero bits leave the status bit unchanged. If a pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R4: With the enable (configuration bit 31) clear, capturing only syndrome bits 20-23 does not lock the block.
- R5: Capturing any implemented bit outside 20-23 locks the block at the same edge, whatever the enable says.
- R6: With the enable set, capturing any implemented bit locks the block at the same edge.
- R7: Pulses that arrive in the lock cycle are captured. While `locked_o` is high, no status bit becomes newly set.
- R8: The lock releases at the edge where the status word becomes zero. A partial clear keeps the block locked.
- R9: Writing configuration bit 31 to zero while locked releases the lock at that edge. The captured bits are left unchanged.
- R10: The configuration word sits at address 1 and stores only bit 31. All other bits, and every address other than 0 and 1, read as zero.
- R11: `rd_data_o` shows, one edge after the address is presented, the word held before that edge. `err_present_o` is high exactly when the status word is non-zero, and it updates at the same edge as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt_i | input | 32 | One-cycle error pulses, one per bit position |
| reg_addr_i | input | 2 | Word address: 0 status, 1 configuration |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| err_present_o | output | 1 | Any status bit set |
| locked_o | output | 1 | Capture frozen |

## Verification
Pulses and writes take effect at the next clock edge. The status word, `locked_o` and `err_present_o` all change at that edge, so every task drives its inputs on a falling edge and samples them on the following falling edge. Read data takes one more edge, because the read register samples the word as it stood before that edge. For that reason the bench presents the address while no pulse or write is active, and samples one falling edge later. The same-cycle cases (a pulse with a clear, two pulses in the locking cycle) drive everything in a single cycle and check the result after that one edge.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] IMPL_MASK_DEF = 32'hA0F7_011F;
  localparam logic [WORD_W-1:0] SYND_MASK_DEF = 32'h00F0_0000;
  localparam int unsigned LOCK_EN_BIT_DEF = 31;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_CONFIG = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/errcap_status.sv
module errcap_status #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         capture_en_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] set_bits_o,
  output logic [W-1:0] status_next_o,
  output logic [W-1:0] status_q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic bit_q;
      logic bit_set;
      logic bit_d;
      assign bit_set = capture_en_i & evt_i[i];
      assign bit_d   = bit_set | (bit_q & ~clr_mask_i[i]);
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= bit_d;
      end
      assign set_bits_o[i]    = bit_set;
      assign status_next_o[i] = bit_d;
      assign status_q_o[i]    = bit_q;
    end else begin : g_none
      assign set_bits_o[i]    = 1'b0;
      assign status_next_o[i] = 1'b0;
      assign status_q_o[i]    = 1'b0;
    end
  end
endmodule

// File: rtl/errcap_config.sv
module errcap_config #(
  parameter int unsigned W = 32,
  parameter int unsigned EN_BIT = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         lock_en_o,
  output logic         lock_en_drop_o,
  output logic [W-1:0] cfg_word_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= 1'b0;
    else if (wr_i) en_q <= wdata_i[EN_BIT];
  end

  assign lock_en_o      = en_q;
  assign lock_en_drop_o = wr_i & en_q & ~wdata_i[EN_BIT];

  always_comb begin
    cfg_word_o         = '0;
    cfg_word_o[EN_BIT] = en_q;
  end
endmodule

// File: rtl/errcap_lock.sv
module errcap_lock #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] SYND_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits_i,
  input  logic         lock_en_i,
  input  logic         lock_en_drop_i,
  input  logic         status_zero_next_i,
  output logic         locked_o
);
  logic locked_q;
  logic any_set;
  logic hard_set;
  logic lock_event;
  logic release_now;

  assign any_set     = |set_bits_i;
  assign hard_set    = |(set_bits_i & ~SYND_MASK);
  assign lock_event  = hard_set | (any_set & lock_en_i);
  assign release_now = status_zero_next_i | lock_en_drop_i;

  always_ff @(posedge clk) begin
    if (rst)             locked_q <= 1'b0;
    else if (lock_event) locked_q <= 1'b1;
    else if (release_now) locked_q <= 1'b0;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/bus_err_latch.sv
module bus_err_latch
  import errcap_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned ADDR_W = 2,
  parameter logic [DATA_W-1:0] IMPL_MASK = IMPL_MASK_DEF,
  parameter logic [DATA_W-1:0] SYND_MASK = SYND_MASK_DEF,
  parameter int unsigned LOCK_EN_BIT = LOCK_EN_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] err_evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_present_o,
  output logic              locked_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CONFIG);

  logic              stat_wr;
  logic              cfg_wr;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] status_next;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] cfg_word;
  logic              lock_en;
  logic              lock_en_drop;
  logic              locked;
  logic [DATA_W-1:0] rd_q;
  logic              present_q;

  assign stat_wr  = reg_we_i & (reg_addr_i == A_STAT);
  assign cfg_wr   = reg_we_i & (reg_addr_i == A_CFG);
  assign clr_mask = stat_wr ? reg_wdata_i : '0;

  errcap_status #(.W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_status (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (err_evt_i),
    .capture_en_i (~locked),
    .clr_mask_i   (clr_mask),
    .set_bits_o   (set_bits),
    .status_next_o(status_next),
    .status_q_o   (status_q)
  );

  errcap_config #(.W(DATA_W), .EN_BIT(LOCK_EN_BIT)) u_config (
    .clk           (clk),
    .rst           (rst),
    .wr_i          (cfg_wr),
    .wdata_i       (reg_wdata_i),
    .lock_en_o     (lock_en),
    .lock_en_drop_o(lock_en_drop),
    .cfg_word_o    (cfg_word)
  );

  errcap_lock #(.W(DATA_W), .SYND_MASK(SYND_MASK)) u_lock (
    .clk               (clk),
    .rst               (rst),
    .set_bits_i        (set_bits),
    .lock_en_i         (lock_en),
    .lock_en_drop_i    (lock_en_drop),
    .status_zero_next_i(status_next == '0),
    .locked_o          (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      present_q <= 1'b0;
    end else begin
      present_q <= |status_next;
      case (reg_addr_i)
        A_STAT:  rd_q <= status_q;
        A_CFG:   rd_q <= cfg_word;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o     = rd_q;
  assign err_present_o = present_q;
  assign locked_o      = locked;
endmodule

// File: rtl/bus_err_latch_chk.sv
module bus_err_latch_chk #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = '1,
  parameter logic [DATA_W-1:0] SYND_MASK = '0,
  parameter int unsigned LOCK_EN_BIT = 31
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] err_evt_i,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] cfg_word,
  input logic              locked_o,
  input logic              err_present_o
);
  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~IMPL_MASK) == '0);

  assert_synd_no_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && !cfg_word[LOCK_EN_BIT] && ((err_evt_i & IMPL_MASK & ~SYND_MASK) == '0))
      |=> !locked_o);

  assert_hard_lock_R5: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && ((err_evt_i & IMPL_MASK & ~SYND_MASK) != '0)) |=> locked_o);

  assert_lofe_lock_R6: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && cfg_word[LOCK_EN_BIT] && ((err_evt_i & IMPL_MASK) != '0)) |=> locked_o);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> ((status_q & ~$past(status_q)) == '0));

  assert_zero_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
    (status_q == '0) |-> !locked_o);

  assert_cfg_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_word & ~(DATA_W'(1) << LOCK_EN_BIT)) == '0);

  assert_present_R11: assert property (@(posedge clk) disable iff (rst)
    err_present_o == (status_q != '0));
endmodule

bind bus_err_latch bus_err_latch_chk #(
  .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK), .SYND_MASK(SYND_MASK), .LOCK_EN_BIT(LOCK_EN_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .err_evt_i    (err_evt_i),
  .status_q     (status_q),
  .cfg_word     (cfg_word),
  .locked_o     (locked_o),
  .err_present_o(err_present_o)
);

// File: tb/bus_err_latch_tb.sv
module bus_err_latch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd;
  logic        present;
  logic        locked;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_err_latch u_dut (
    .clk(clk), .rst(rst), .err_evt_i(evt), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .rd_data_o(rd), .err_present_o(present), .locked_o(locked)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] m);
    evt = m; tick; evt = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1; tick; we = 1'b0; wdata = '0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] v);
    addr = a; tick; v = rd;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 rd", rd, 32'h0);
    chk("R1 present", {31'b0, present}, 32'h0);
    chk("R1 locked", {31'b0, locked}, 32'h0);
    rdreg(2'd0, v); chk("R1 status", v, 32'h0);
    rdreg(2'd1, v); chk("R1 config", v, 32'h0);
  endtask

  task automatic t_syndrome;
    logic [31:0] v;
    pulse(32'h0010_0000);
    chk("R11 present same edge", {31'b0, present}, 32'h1);
    chk("R4 no lock", {31'b0, locked}, 32'h0);
    pulse(32'h0000_0020);
    rdreg(2'd0, v); chk("R2 sticky, unimpl ignored", v, 32'h0010_0000);
    wr(2'd0, 32'h0);
    rdreg(2'd0, v); chk("R3 zero write keeps", v, 32'h0010_0000);
    wr(2'd0, 32'h0010_0000);
    chk("R3 w1c present", {31'b0, present}, 32'h0);
    rdreg(2'd0, v); chk("R3 w1c", v, 32'h0);
  endtask

  task automatic t_hard_lock;
    logic [31:0] v;
    evt = 32'h0000_0005; tick; evt = '0;
    chk("R5 lock", {31'b0, locked}, 32'h1);
    rdreg(2'd0, v); chk("R7 same-cycle capture", v, 32'h0000_0005);
    pulse(32'h0000_0012);
    rdreg(2'd0, v); chk("R7 dropped", v, 32'h0000_0005);
    wr(2'd0, 32'h0000_0001);
    chk("R8 partial keeps lock", {31'b0, locked}, 32'h1);
    wr(2'd0, 32'h0000_0004);
    chk("R8 zero releases", {31'b0, locked}, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    wr(2'd1, 32'h0);
    evt = 32'h0020_0000; addr = 2'd0; wdata = 32'h0020_0000; we = 1'b1;
    tick; evt = '0; we = 1'b0; wdata = '0;
    rdreg(2'd0, v); chk("R3 set beats clear", v, 32'h0020_0000);
    wr(2'd0, 32'hFFFF_FFFF);
    rdreg(2'd0, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_lofe;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    rdreg(2'd1, v); chk("R10 config bits", v, 32'h8000_0000);
    rdreg(2'd2, v); chk("R10 unused addr", v, 32'h0);
    pulse(32'h0020_0000);
    chk("R6 lock on syndrome", {31'b0, locked}, 32'h1);
    pulse(32'h0040_0000);
    rdreg(2'd0, v); chk("R7 frozen", v, 32'h0020_0000);
    wr(2'd1, 32'h0);
    chk("R9 release", {31'b0, locked}, 32'h0);
    rdreg(2'd0, v); chk("R9 bits kept", v, 32'h0020_0000);
    pulse(32'h0040_0000);
    chk("R4 no lock after release", {31'b0, locked}, 32'h0);
    rdreg(2'd0, v); chk("R2 capture after release", v, 32'h0060_0000);
    pulse(32'h8000_0000);
    chk("R5 bit31 locks", {31'b0, locked}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R8 release on clear-all", {31'b0, locked}, 32'h0);
    chk("R11 present off", {31'b0, present}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_syndrome;
    t_hard_lock;
    t_set_wins;
    t_lofe;
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule